// File: doc/BRIEF.md
# Secure Address Region Controller

This block holds the address windows that an encrypting memory bridge applies to traffic. Software reaches it through a single-cycle APB-style slave. For each of eight slots it writes a lower and an upper address, both aligned to 4 KB, and a per-slot security flag. It then asks for one slot to become live. The controller checks the request first. If the request passes, a programmable settling interval runs, and only after it does the slot show as live. At that point its bounds and security flag appear on dedicated outputs that feed the bridge datapath.

Turning a slot off works the same way. The slot's stored settings are wiped at once, but the live outputs stay until the settling interval ends. Requests that fail a check leave a sticky error flag for that slot, and reading the error register clears it.

The sequencing lives in a small state machine with three states:
- `SY_IDLE`: nothing is pending.
- `SY_ENABLE`: an activation is settling.
- `SY_DISABLE`: a deactivation is settling.

It has four transitions:
- IDLE→ENABLE on an accepted activation.
- IDLE→DISABLE on a deactivation that hits the live slot.
- ENABLE→IDLE when the settle counter expires; the pending slot goes live.
- DISABLE→IDLE when the settle counter expires; the live slot is dropped.

Register map. Byte offsets are given with the default of 8 slots.
- Slot lower bound: `8*i`.
- Slot upper bound: `8*i+4`.
- Security flags: `0x40`, one bit per slot.
- Activate: `0x44`, write-one.
- Deactivate: `0x48`, write-one.
- Live status: `0x4C`, one bit per slot.
- Settling: `0x50`, bit 0.
- Error flags: `0x54`, one bit per slot.

Top module: `xregion_cfg`

## Requirements
- R1: After reset every slot register, the security, status, settling and error registers read zero, and `act_valid` is 0.
- R2: Bits [11:0] of a slot's lower (`8*i`) and upper (`8*i+4`) bound are dropped on write and read back as zero.
- R3: Bit i of the security register (`0x40`) is slot i's flag: 1 means non-secure (reachable by both worlds), 0 means secure-only. When a slot goes live its flag appears on `act_sec`.
- R4: A write to the activate register (`0x44`) whose low 8 bits do not have exactly one bit set is ignored entirely: no settling, no status change, no error.
- R5: An accepted activation of slot i raises bit 0 of the settling register (`0x50`). Exactly SYNC_CYCLES clock cycles after the write's access cycle, bit i of the status register (`0x4C`) and `act_valid` rise, with `act_base` and `act_top` showing that slot's bounds.
- R6: At most one slot is live. An activation that passes every check while another slot is live is ignored, with no error.
- R7: An activation sets error bit i (`0x54`) instead of starting anything when any of these holds: upper bound ≤ lower bound; the slot's range [lower, upper) overlaps the live slot; or lower < WIN_BASE or upper > WIN_LIMIT.
- R8: Reading the error register returns the latched bits and clears them all.
- R9: Writing 1 to bit i of the deactivate register (`0x48`) clears slot i's bounds and security bit at once. If slot i is live, its status bit and `act_valid` fall only after SYNC_CYCLES cycles.
- R10: While the settling bit is 1, writes to the activate and deactivate registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | PAW (8) | Byte address |
| pwdata | input | AW (32) | Write data |
| prdata | output | AW (32) | Read data, valid during the access phase |
| act_valid | output | 1 | A slot is live |
| act_base | output | AW (32) | Live slot lower bound |
| act_top | output | AW (32) | Live slot upper bound |
| act_sec | output | 1 | Live slot security flag |

## Verification
The checker watches several properties on every cycle:
- At most one status bit is ever set.
- Status changes only out of a settling cycle.
- A live slot always has consistent, in-window bounds.
- A read of the error register always leaves it empty.

The directed scenarios show the rest:
- The exact settling latency.
- The rejection of multi-bit and busy-time requests.
- Each of the three error causes, observed at the error register.
- The immediate wipe of a slot on deactivation.

// File: rtl/xregion_pkg.sv
package xregion_pkg;
    typedef enum logic [1:0] {
        SY_IDLE    = 2'd0,
        SY_ENABLE  = 2'd1,
        SY_DISABLE = 2'd2
    } sync_state_e;

    localparam int unsigned PAGE_BITS = 12;
endpackage

// File: rtl/xregion_regs.sv
module xregion_regs #(
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 32,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_base_en,
    input  logic                    wr_top_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [AW-13:0]          wr_page,
    input  logic                    sec_we,
    input  logic [N-1:0]            sec_wdata,
    input  logic [N-1:0]            clr_mask,
    output logic [N-1:0][AW-1:0]    base_o,
    output logic [N-1:0][AW-1:0]    top_o,
    output logic [N-1:0]            sec_o
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_o[g] <= '0;
                top_o[g]  <= '0;
                sec_o[g]  <= 1'b0;
            end else if (clr_mask[g]) begin
                base_o[g] <= '0;
                top_o[g]  <= '0;
                sec_o[g]  <= 1'b0;
            end else begin
                if (wr_base_en && wr_idx == IDX_W'(g))
                    base_o[g] <= {wr_page, 12'b0};
                if (wr_top_en && wr_idx == IDX_W'(g))
                    top_o[g] <= {wr_page, 12'b0};
                if (sec_we)
                    sec_o[g] <= sec_wdata[g];
            end
        end
    end
endmodule

// File: rtl/xregion_check.sv
module xregion_check #(
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 32,
    parameter logic [AW-1:0] WIN_BASE  = '0,
    parameter logic [AW-1:0] WIN_LIMIT = '1,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic [N-1:0][AW-1:0]    base_all,
    input  logic [N-1:0][AW-1:0]    top_all,
    input  logic                    act_valid,
    input  logic [IDX_W-1:0]        act_idx,
    input  logic [AW-1:0]           act_base,
    input  logic [AW-1:0]           act_top,
    output logic                    bad
);
    logic [AW-1:0] c_base, c_top;
    logic inconsistent, overlap, outside;

    always_comb begin
        c_base       = base_all[idx];
        c_top        = top_all[idx];
        inconsistent = (c_top <= c_base);
        overlap      = act_valid && (act_idx != idx) &&
                       (c_base < act_top) && (act_base < c_top);
        outside      = (c_base < WIN_BASE) || (c_top > WIN_LIMIT);
        bad          = inconsistent || overlap || outside;
    end
endmodule

// File: rtl/xregion_sync.sv
module xregion_sync
    import xregion_pkg::*;
#(
    parameter int unsigned N           = 8,
    parameter int unsigned AW          = 32,
    parameter int unsigned SYNC_CYCLES = 16,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned CNT_W = $clog2(SYNC_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_go,
    input  logic              dis_go,
    input  logic [IDX_W-1:0]  en_idx,
    input  logic [AW-1:0]     cand_base,
    input  logic [AW-1:0]     cand_top,
    input  logic              cand_sec,
    output logic              busy,
    output logic [N-1:0]      es,
    output logic [IDX_W-1:0]  act_idx,
    output logic [AW-1:0]     act_base,
    output logic [AW-1:0]     act_top,
    output logic              act_sec
);
    sync_state_e state, state_n;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] pend_idx;
    logic [AW-1:0]    pend_base, pend_top;
    logic             pend_sec;

    always_comb begin
        state_n = state;
        unique case (state)
            SY_IDLE:    if (en_go) state_n = SY_ENABLE;
                        else if (dis_go) state_n = SY_DISABLE;
            SY_ENABLE,
            SY_DISABLE: if (cnt == '0) state_n = SY_IDLE;
            default:    state_n = SY_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SY_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            pend_idx  <= '0;
            pend_base <= '0;
            pend_top  <= '0;
            pend_sec  <= 1'b0;
            es        <= '0;
            act_idx   <= '0;
            act_base  <= '0;
            act_top   <= '0;
            act_sec   <= 1'b0;
        end else if (state == SY_IDLE) begin
            if (en_go) begin
                cnt       <= CNT_W'(SYNC_CYCLES - 1);
                pend_idx  <= en_idx;
                pend_base <= cand_base;
                pend_top  <= cand_top;
                pend_sec  <= cand_sec;
            end else if (dis_go) begin
                cnt <= CNT_W'(SYNC_CYCLES - 1);
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (state == SY_ENABLE) begin
            es       <= N'(1) << pend_idx;
            act_idx  <= pend_idx;
            act_base <= pend_base;
            act_top  <= pend_top;
            act_sec  <= pend_sec;
        end else begin
            es       <= '0;
            act_base <= '0;
            act_top  <= '0;
            act_sec  <= 1'b0;
        end
    end

    assign busy = (state != SY_IDLE);
endmodule

// File: rtl/xregion_cfg.sv
module xregion_cfg #(
    parameter int unsigned N           = 8,
    parameter int unsigned AW          = 32,
    parameter int unsigned PAW         = 8,
    parameter int unsigned SYNC_CYCLES = 16,
    parameter logic [AW-1:0] WIN_BASE  = 32'h0001_0000,
    parameter logic [AW-1:0] WIN_LIMIT = 32'h8000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            psel,
    input  logic            penable,
    input  logic            pwrite,
    input  logic [PAW-1:0]  paddr,
    input  logic [AW-1:0]   pwdata,
    output logic [AW-1:0]   prdata,
    output logic            act_valid,
    output logic [AW-1:0]   act_base,
    output logic [AW-1:0]   act_top,
    output logic            act_sec
);
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int unsigned WW    = PAW - 2;
    localparam logic [WW-1:0] SLOT_END = WW'(2 * N);
    localparam logic [WW-1:0] SEC_W    = WW'(2 * N);
    localparam logic [WW-1:0] EN_W     = WW'(2 * N + 1);
    localparam logic [WW-1:0] DIS_W    = WW'(2 * N + 2);
    localparam logic [WW-1:0] STAT_W   = WW'(2 * N + 3);
    localparam logic [WW-1:0] SYNC_W   = WW'(2 * N + 4);
    localparam logic [WW-1:0] ERR_W    = WW'(2 * N + 5);

    logic [WW-1:0] word;
    logic acc, wr, rd, in_slots;
    logic [IDX_W-1:0] slot_idx, enc_idx;
    logic [N-1:0] req_mask, es, sec_all, err_q, clr_mask;
    logic [N-1:0][AW-1:0] base_all, top_all;
    logic en_req, en_ok, bad, busy, en_go, dis_req, dis_go, err_set, err_rd;
    logic [IDX_W-1:0] act_idx;

    assign word     = paddr[PAW-1:2];
    assign acc      = psel && penable && (paddr[1:0] == 2'b00);
    assign wr       = acc && pwrite;
    assign rd       = acc && !pwrite;
    assign in_slots = (word < SLOT_END);
    assign slot_idx = word[IDX_W:1];
    assign req_mask = pwdata[N-1:0];

    always_comb begin
        enc_idx = '0;
        for (int i = 0; i < N; i++)
            if (req_mask[i]) enc_idx = IDX_W'(i);
    end

    assign en_req   = wr && (word == EN_W) && $onehot(req_mask) && !busy;
    assign en_ok    = en_req && !bad;
    assign en_go    = en_ok && !act_valid;
    assign err_set  = en_req && bad;
    assign dis_req  = wr && (word == DIS_W) && !busy;
    assign clr_mask = dis_req ? req_mask : '0;
    assign dis_go   = dis_req && |(req_mask & es);
    assign err_rd   = rd && (word == ERR_W);
    assign act_valid = |es;

    xregion_regs #(.N(N), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_base_en(wr && in_slots && !word[0]),
        .wr_top_en(wr && in_slots && word[0]),
        .wr_idx(slot_idx), .wr_page(pwdata[AW-1:12]),
        .sec_we(wr && (word == SEC_W)), .sec_wdata(req_mask),
        .clr_mask(clr_mask),
        .base_o(base_all), .top_o(top_all), .sec_o(sec_all)
    );

    xregion_check #(.N(N), .AW(AW), .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT)) u_check (
        .idx(enc_idx), .base_all(base_all), .top_all(top_all),
        .act_valid(act_valid), .act_idx(act_idx),
        .act_base(act_base), .act_top(act_top), .bad(bad)
    );

    xregion_sync #(.N(N), .AW(AW), .SYNC_CYCLES(SYNC_CYCLES)) u_sync (
        .clk(clk), .rst_n(rst_n), .en_go(en_go), .dis_go(dis_go),
        .en_idx(enc_idx), .cand_base(base_all[enc_idx]),
        .cand_top(top_all[enc_idx]), .cand_sec(sec_all[enc_idx]),
        .busy(busy), .es(es), .act_idx(act_idx),
        .act_base(act_base), .act_top(act_top), .act_sec(act_sec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_q <= '0;
        else if (err_rd)  err_q <= '0;
        else if (err_set) err_q[enc_idx] <= 1'b1;
    end

    always_comb begin
        prdata = '0;
        if (in_slots)
            prdata = word[0] ? top_all[slot_idx] : base_all[slot_idx];
        else if (word == SEC_W)  prdata = AW'(sec_all);
        else if (word == STAT_W) prdata = AW'(es);
        else if (word == SYNC_W) prdata = AW'(busy);
        else if (word == ERR_W)  prdata = AW'(err_q);
    end
endmodule

// File: rtl/xregion_cfg_chk.sv
module xregion_cfg_chk #(
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 32,
    parameter logic [AW-1:0] WIN_BASE  = '0,
    parameter logic [AW-1:0] WIN_LIMIT = '1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  es,
    input logic          busy,
    input logic [N-1:0]  err,
    input logic          err_rd,
    input logic          act_valid,
    input logic [AW-1:0] act_base,
    input logic [AW-1:0] act_top
);
    // R6
    one_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(es));

    // R5
    status_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(es) |-> $past(busy));

    // R7
    live_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (act_top > act_base));

    // R7
    live_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (act_base >= WIN_BASE && act_top <= WIN_LIMIT));

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_rd |=> (err == '0));
endmodule

bind xregion_cfg xregion_cfg_chk #(
    .N(N), .AW(AW), .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .es(es), .busy(busy), .err(err_q),
    .err_rd(err_rd), .act_valid(act_valid),
    .act_base(act_base), .act_top(act_top)
);

// File: tb/xregion_cfg_tb.sv
`timescale 1ns/1ps
module xregion_cfg_tb;
    localparam int SYNC = 16;
    localparam logic [7:0] A_SEC = 8'h40, A_EN = 8'h44, A_DIS = 8'h48,
                           A_STAT = 8'h4C, A_SYNC = 8'h50, A_ERR = 8'h54;

    logic clk = 1'b0, rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata, act_base, act_top;
    logic act_valid, act_sec;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xregion_cfg u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .act_valid(act_valid), .act_base(act_base), .act_top(act_top),
        .act_sec(act_sec)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // counts cycles until act_valid reaches lvl, starting right after a write
    task automatic wait_live(logic lvl, int limit, output int n);
        n = 0;
        while (act_valid !== lvl && n < limit) begin
            @(posedge clk); @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        check("R1 act_valid", 32'(act_valid), 0);
        rd_chk("R1 status", A_STAT, 0);
        rd_chk("R1 sync", A_SYNC, 0);
        rd_chk("R1 err", A_ERR, 0);
        rd_chk("R1 base0", 8'h00, 0);
        rd_chk("R1 sec", A_SEC, 0);
    endtask

    task automatic t_page;
        wr(8'h00, 32'h0002_3ABC);
        rd_chk("R2 base0 low bits", 8'h00, 32'h0002_3000);
        wr(8'h04, 32'h0004_5FFF);
        rd_chk("R2 top0 low bits", 8'h04, 32'h0004_5000);
    endtask

    task automatic t_multi;
        wr(A_EN, 32'h3);
        rd_chk("R4 sync idle", A_SYNC, 0);
        repeat (SYNC + 4) @(negedge clk);
        rd_chk("R4 status", A_STAT, 0);
        rd_chk("R4 err", A_ERR, 0);
    endtask

    task automatic t_enable;
        int n;
        wr(A_SEC, 32'h1);
        rd_chk("R3 sec", A_SEC, 32'h1);
        wr(A_EN, 32'h1);
        wait_live(1'b1, 100, n);
        check("R5 latency", 32'(n), SYNC);
        check("R5 act_base", act_base, 32'h0002_3000);
        check("R5 act_top", act_top, 32'h0004_5000);
        check("R3 act_sec", 32'(act_sec), 1);
        rd_chk("R5 status", A_STAT, 32'h1);
        rd_chk("R5 sync done", A_SYNC, 0);
    endtask

    task automatic t_second;
        wr(8'h08, 32'h0010_0000);
        wr(8'h0C, 32'h0011_0000);
        wr(A_EN, 32'h2);
        repeat (SYNC + 4) @(negedge clk);
        rd_chk("R6 status", A_STAT, 32'h1);
        rd_chk("R6 err", A_ERR, 0);
        check("R6 act_base", act_base, 32'h0002_3000);
    endtask

    task automatic t_errors;
        wr(8'h10, 32'h0003_0000);
        wr(8'h14, 32'h0005_0000);
        wr(A_EN, 32'h4);
        rd_chk("R7 overlap err", A_ERR, 32'h4);
        rd_chk("R8 err cleared", A_ERR, 0);
        wr(8'h18, 32'h0002_0000);
        wr(8'h1C, 32'h0002_0000);
        wr(A_EN, 32'h8);
        rd_chk("R7 bounds err", A_ERR, 32'h8);
        wr(8'h20, 32'h0000_8000);
        wr(8'h24, 32'h0000_9000);
        wr(A_EN, 32'h10);
        rd_chk("R7 below window err", A_ERR, 32'h10);
        wr(8'h28, 32'h7FFF_0000);
        wr(8'h2C, 32'h8001_0000);
        wr(A_EN, 32'h20);
        rd_chk("R7 above window err", A_ERR, 32'h20);
        rd_chk("R7 status unchanged", A_STAT, 32'h1);
    endtask

    task automatic t_disable;
        int n;
        wr(A_DIS, 32'h1);
        rd_chk("R9 sync busy", A_SYNC, 32'h1);
        rd_chk("R9 base0 wiped", 8'h00, 0);
        rd_chk("R9 sec wiped", A_SEC, 0);
        wr(A_EN, 32'h2);
        check("R9 still live", 32'(act_valid), 1);
        wait_live(1'b0, 100, n);
        check("R9 dropped", 32'(act_valid), 0);
        repeat (SYNC + 4) @(negedge clk);
        rd_chk("R10 enable ignored", A_STAT, 0);
    endtask

    task automatic t_reenable;
        int n;
        wr(A_EN, 32'h2);
        wr(A_DIS, 32'h2);
        wait_live(1'b1, 100, n);
        rd_chk("R6 new slot live", A_STAT, 32'h2);
        check("R6 new act_base", act_base, 32'h0010_0000);
        rd_chk("R10 disable ignored", 8'h08, 32'h0010_0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_page();
        t_multi();
        t_enable();
        t_second();
        t_errors();
        t_disable();
        t_reenable();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule